// File: doc/BRIEF.md
# External Status Change Interrupt Latch

This block follows six status sources of one serial channel and raises a status interrupt when any enabled source changes level. Three of them are modem-control pins that arrive asynchronously: clear-to-send, sync/hunt and carrier detect. The other three are internal conditions that are already synchronous: break/abort, transmit underrun/end-of-message and baud counter zero. Either a rising or a falling edge counts as a change.

The host reads an 8-bit status byte. When a change on an enabled source is caught, the six source bits of that byte freeze at the values that caused the event, and the pending latch sets. They stay frozen until the host issues the reset-status command. After release the bits track the live sources again. A change that happened while they were frozen is caught on the next cycle and raises a fresh event. The latched pending flag feeds the chip's interrupt prioritizer, and a gated request output honours the channel and master interrupt enables.

Top module: `ext_status_latch`

## Requirements
- R1: After reset the six source bits of `status` are 0 and both `stat_pend` and `stat_irq` are 0.
- R2: The three pins pass through a two-flop synchronizer. A pin change driven before clock edge 1 shows in `status` after edge 3 and not after edge 2. The internal sources show after the first edge.
- R3: The `status` bit positions are: 7 break/abort, 6 transmit underrun, 5 CTS, 4 sync/hunt, 3 DCD, 2 transmit buffer empty, 1 zero count, 0 receive character ready. Bits 2 and 0 follow their inputs combinationally at all times.
- R4: While not pending, a rising or falling edge of a source whose `ie_mask` bit is 1 sets `stat_pend` at the edge that updates `status`.
- R5: A change on a source whose `ie_mask` bit is 0 does not set `stat_pend`. While not pending, its status bit still tracks the source.
- R6: While `stat_pend` is 1, the six source bits of `status` hold their value whatever the sources do.
- R7: `stat_irq` is 1 only when `stat_pend`, `stat_ie` and `master_ie` are all 1. The pending latch sets regardless of those two enables.
- R8: A cycle with `cmd_valid`=1 and `cmd_code[5:3]`=3'b010 (code 0x10) clears `stat_pend` at the next edge. Any other command code has no effect.
- R9: After the release, a source that changed while frozen sets `stat_pend` again one edge later, and `status` then shows its new value.
- R10: The enables sit in `ie_mask` bits 7, 6, 5, 4, 3 and 1, matching the status positions. Bits 2 and 0 of `ie_mask` are ignored, and so are changes of transmit-empty and receive-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_pin | input | 1 | Clear-to-send pin, asynchronous |
| sync_pin | input | 1 | Sync/hunt pin, asynchronous |
| dcd_pin | input | 1 | Carrier detect pin, asynchronous |
| brk_abort | input | 1 | Break/abort condition, synchronous |
| tx_underrun | input | 1 | Transmit underrun/end-of-message, synchronous |
| zero_count | input | 1 | Baud counter reached zero, synchronous |
| tx_empty | input | 1 | Transmit buffer empty, shown live |
| rx_ready | input | 1 | Receive character available, shown live |
| ie_mask | input | 8 | Per-source change enables |
| stat_ie | input | 1 | Channel status-interrupt enable |
| master_ie | input | 1 | Master interrupt enable |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command byte |
| status | output | 8 | Status byte |
| stat_pend | output | 1 | Latched status-change pending flag |
| stat_irq | output | 1 | Gated status interrupt request |

## Verification
A wrong snapshot or pending state shows at `status` and `stat_pend` on the sampling point right after the faulty edge. The observable symptoms are a byte that moves while it should be frozen, a pending flag that fails to rise one edge after a change, and one that survives the reset command. A synchronizer that is too short or too long moves the pin bits one cycle early or late. A lost change during the frozen window shows up as a missing re-raise one edge after release. A cycle-accurate model of the requirements runs beside the design, so every one of these is caught on the first cycle it occurs.

// File: rtl/ext_status_latch.sv
module ext_status_latch #(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_SRC     = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_pin,
  input  logic       sync_pin,
  input  logic       dcd_pin,
  input  logic       brk_abort,
  input  logic       tx_underrun,
  input  logic       zero_count,
  input  logic       tx_empty,
  input  logic       rx_ready,
  input  logic [7:0] ie_mask,
  input  logic       stat_ie,
  input  logic       master_ie,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  output logic [7:0] status,
  output logic       stat_pend,
  output logic       stat_irq
);
  localparam int NUM_PIN = 3;

  logic [NUM_PIN-1:0] pin_in, pin_s;
  logic [NUM_PIN-1:0] sync_ff [SYNC_STAGES];
  logic [NUM_SRC-1:0] live, snap, enm, diff;
  logic               hit, rst_cmd, pend_q;

  assign pin_in = {cts_pin, sync_pin, dcd_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_ff[i] <= '0;
    end else begin
      sync_ff[0] <= pin_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_ff[i] <= sync_ff[i-1];
    end
  end

  assign pin_s   = sync_ff[SYNC_STAGES-1];
  assign live    = {brk_abort, tx_underrun, pin_s, zero_count};
  assign enm     = {ie_mask[7:3], ie_mask[1]};
  assign diff    = (live ^ snap) & enm;
  assign hit     = |diff;
  assign rst_cmd = cmd_valid && (cmd_code[5:3] == 3'b010);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap   <= '0;
      pend_q <= 1'b0;
    end else if (pend_q) begin
      if (rst_cmd) pend_q <= 1'b0;
    end else begin
      snap <= live;
      if (hit) pend_q <= 1'b1;
    end
  end

  assign status    = {snap[5:1], tx_empty, snap[0], rx_ready};
  assign stat_pend = pend_q;
  assign stat_irq  = pend_q & stat_ie & master_ie;

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_pend && !rst_cmd) |=> ($stable(status[7:3]) && $stable(status[1]))); // R6

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_pend && rst_cmd) |=> !stat_pend); // R8

  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_pend) |-> ({status[7:3], status[1]} != $past({status[7:3], status[1]}))); // R4

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_pend && ((live ^ snap) & enm) == '0) |=> !stat_pend); // R5

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_irq) |-> (stat_pend && master_ie)); // R7
endmodule

// File: tb/sim_ext_status_latch.sv
module sim_ext_status_latch;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cts_pin = 0, sync_pin = 0, dcd_pin = 0;
  logic brk_abort = 0, tx_underrun = 0, zero_count = 0, tx_empty = 0, rx_ready = 0;
  logic [7:0] ie_mask = 8'h00, cmd_code = 8'h00;
  logic stat_ie = 0, master_ie = 0, cmd_valid = 0;
  logic [7:0] status;
  logic stat_pend, stat_irq;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_status_latch u0 (
    .clk, .rst_n, .cts_pin, .sync_pin, .dcd_pin, .brk_abort, .tx_underrun,
    .zero_count, .tx_empty, .rx_ready, .ie_mask, .stat_ie, .master_ie,
    .cmd_valid, .cmd_code, .status, .stat_pend, .stat_irq
  );

  // requirement model
  logic [2:0] m_s1, m_s2;
  logic [5:0] m_snap;
  logic       m_pend;

  function automatic logic [5:0] m_live(input logic [2:0] ps);
    return {brk_abort, tx_underrun, ps, zero_count};
  endfunction
  function automatic logic [5:0] m_en(input logic [7:0] m);
    return {m[7:3], m[1]};
  endfunction
  function automatic logic [7:0] m_status();
    return {m_snap[5:1], tx_empty, m_snap[0], rx_ready};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_snap <= '0; m_pend <= 1'b0;
    end else begin
      m_s1 <= {cts_pin, sync_pin, dcd_pin};
      m_s2 <= m_s1;
      if (m_pend) begin
        if (cmd_valid && cmd_code[5:3] == 3'b010) m_pend <= 1'b0;
      end else begin
        m_snap <= m_live(m_s2);
        if (|((m_live(m_s2) ^ m_snap) & m_en(ie_mask))) m_pend <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk_model(input string tag);
    chk(status === m_status(), tag, status, m_status());
    chk(stat_pend === m_pend, tag, {7'b0, stat_pend}, {7'b0, m_pend});
    chk(stat_irq === (m_pend & stat_ie & master_ie), tag, {7'b0, stat_irq},
        {7'b0, m_pend & stat_ie & master_ie});
  endtask

  task automatic release_cmd();
    cmd_valid = 1; cmd_code = 8'h10;
    tick();
    cmd_valid = 0; cmd_code = 8'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick(2);
    rst_n = 1;
    tick();
    // R1 reset state
    chk(status === 8'h00, "R1 status", status, 8'h00);
    chk(stat_pend === 1'b0, "R1 pend", {7'b0, stat_pend}, 8'h00);
    chk(stat_irq === 1'b0, "R1 irq", {7'b0, stat_irq}, 8'h00);

    // R2 synchronizer latency, R3 bit 5, R4 rising edge
    ie_mask = 8'hFA; stat_ie = 1; master_ie = 1;
    cts_pin = 1;
    tick(2);
    chk(status[5] === 1'b0, "R2 early", status, 8'h00);
    tick();
    chk(status === 8'h20, "R2 R3 cts bit", status, 8'h20);
    chk(stat_pend === 1'b1, "R4 rise", {7'b0, stat_pend}, 8'h01);
    chk(stat_irq === 1'b1, "R7 irq on", {7'b0, stat_irq}, 8'h01);

    // R6 frozen; R3 live bits
    cts_pin = 0; tx_empty = 1; rx_ready = 1;
    #1;
    chk(status === 8'h25, "R3 live bits", status, 8'h25);
    tick(4);
    chk(status === 8'h25, "R6 frozen", status, 8'h25);

    // R8 other code ignored, then 0x10 releases
    cmd_valid = 1; cmd_code = 8'h28;
    tick();
    cmd_valid = 0;
    chk(stat_pend === 1'b1, "R8 wrong code", {7'b0, stat_pend}, 8'h01);
    cmd_valid = 1; cmd_code = 8'h10;
    tick();
    cmd_valid = 0; cmd_code = 8'h00;
    chk(stat_pend === 1'b0, "R8 release", {7'b0, stat_pend}, 8'h00);
    chk(status === 8'h25, "R8 status kept", status, 8'h25);
    // R9 change during freeze re-raises
    tick();
    chk(stat_pend === 1'b1, "R9 re-raise", {7'b0, stat_pend}, 8'h01);
    chk(status === 8'h05, "R9 new value", status, 8'h05);
    release_cmd();

    // R5 masked source, R10 positions
    ie_mask = 8'h02;
    brk_abort = 1;
    tick();
    chk(status === 8'h85, "R5 tracks", status, 8'h85);
    chk(stat_pend === 1'b0, "R5 no pend", {7'b0, stat_pend}, 8'h00);
    zero_count = 1;
    tick();
    chk(stat_pend === 1'b1, "R10 bit1 enable", {7'b0, stat_pend}, 8'h01);
    chk(status === 8'h87, "R10 bit1 status", status, 8'h87);

    // R7 gating
    stat_ie = 0; #1;
    chk(stat_irq === 1'b0, "R7 stat_ie off", {7'b0, stat_irq}, 8'h00);
    stat_ie = 1; master_ie = 0; #1;
    chk(stat_irq === 1'b0, "R7 master off", {7'b0, stat_irq}, 8'h00);
    chk(stat_pend === 1'b1, "R7 pend kept", {7'b0, stat_pend}, 8'h01);
    master_ie = 1;
    release_cmd();

    // R4 falling edge
    zero_count = 0;
    tick();
    chk(stat_pend === 1'b1, "R4 fall", {7'b0, stat_pend}, 8'h01);
    chk(status === 8'h85, "R4 fall status", status, 8'h85);
    release_cmd();

    // R10 bits 2 and 0 ignored
    ie_mask = 8'h05;
    tx_empty = 0; rx_ready = 0;
    tick(2);
    tx_empty = 1; rx_ready = 1;
    tick(2);
    chk(stat_pend === 1'b0, "R10 ignored bits", {7'b0, stat_pend}, 8'h00);

    // random phase against model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 0) cts_pin = ~cts_pin;
      if (r[7:4] == 0) sync_pin = ~sync_pin;
      if (r[11:8] == 0) dcd_pin = ~dcd_pin;
      if (r[15:12] == 0) brk_abort = ~brk_abort;
      if (r[19:16] == 0) tx_underrun = ~tx_underrun;
      if (r[23:20] == 0) zero_count = ~zero_count;
      tx_empty = r[24];
      rx_ready = r[25];
      cmd_valid = (r[28:26] == 0);
      cmd_code = r[29] ? 8'h10 : {2'b00, r[31:29], 3'b000};
      if (r[31:27] == 0) ie_mask = $urandom;
      if (r[30:26] == 1) begin stat_ie = $urandom; master_ie = $urandom; end
      tick();
      chk_model("R4 R6 R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule